// File: doc/BRIEF.md
# Interrupt Acceptance and Status Flag Unit

This block holds the processor's interrupt status: an interrupt enable flag, a stack select flag and a 3-bit processor priority level. Each cycle it looks at three kinds of request: fixed-vector sources such as reset or undefined instruction, a software interrupt instruction with its 6-bit number, and one maskable request that has already been arbitrated and carries a priority and a vector number. It decides in the same cycle whether one of them is taken.

When a request is taken, `ack_o` rises for that cycle. The block reports which kind of request was taken and its number. For fixed sources it also gives the vector fetch address. It presents the flag and level values from before the acknowledge so the surrounding core can save them. The flags are updated on the next clock edge. Software can also load the flags through a write port. The stack pointer select output follows the stack select flag.

Top module: `irq_accept`

## Requirements
- R1: After reset the enable flag, the stack select flag and the priority level all read 0, and no acknowledge is given without a request.
- R2: A maskable request is taken only while the enable flag is 1. While the flag is 0 the request produces no acknowledge.
- R3: A maskable request is taken only when its level is strictly greater than the current priority level. A level equal to or below it is not acknowledged.
- R4: Every acknowledge clears the enable flag on the following clock edge.
- R5: The stack select flag is cleared on the following edge after a fixed or maskable acknowledge, and after a software interrupt numbered 0 to 31. A software interrupt numbered 32 to 63 leaves the flag unchanged.
- R6: `sp_sel_o` is 1 (user stack) when the stack select flag is 1, and 0 (interrupt stack) when it is 0.
- R7: Fixed sources are taken regardless of the enable flag and the priority level. When several fixed sources are requested together, the one with the highest index wins. Index 8 is reset, and indices 0 to 7 are undefined instruction, overflow, break, address match, single step, watchdog/oscillator/voltage monitor, address break and a reserved entry.
- R8: For a fixed acknowledge, `vec_addr_o` equals 0x0FFDC plus 4 times the source index. For every other outcome it is 0.
- R9: During the acknowledge cycle, `saved_ie_o`, `saved_sps_o` and `saved_ipl_o` show the values held before the acknowledge.
- R10: A flag write with no acknowledge in the same cycle loads all three fields on the next edge. In a cycle that acknowledges, the write is ignored entirely.
- R11: When requests arrive together, fixed sources come before the software interrupt, and the software interrupt comes before the maskable request. `ack_kind_o` is 0 for maskable, 1 for fixed and 2 for software. `ack_num_o` carries the vector number, the fixed index or the software number respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreq_valid_i | input | 1 | Maskable request pending |
| mreq_level_i | input | 3 | Maskable request priority |
| mreq_vec_i | input | 6 | Maskable request vector number |
| fixed_req_i | input | 9 | Fixed-source request strobes, index 8 = reset |
| swi_valid_i | input | 1 | Software interrupt instruction strobe |
| swi_num_i | input | 6 | Software interrupt number |
| wr_en_i | input | 1 | Flag write strobe |
| wr_ie_i | input | 1 | Enable flag write value |
| wr_sps_i | input | 1 | Stack select write value |
| wr_ipl_i | input | 3 | Priority level write value |
| ack_o | output | 1 | Request taken this cycle |
| ack_kind_o | output | 2 | 0 maskable, 1 fixed, 2 software |
| ack_num_o | output | 6 | Vector number, fixed index or software number |
| vec_addr_o | output | 20 | Fixed vector fetch address |
| saved_ie_o | output | 1 | Enable flag before acknowledge |
| saved_sps_o | output | 1 | Stack select before acknowledge |
| saved_ipl_o | output | 3 | Priority level before acknowledge |
| ie_o | output | 1 | Current enable flag |
| sps_o | output | 1 | Current stack select flag |
| ipl_o | output | 3 | Current priority level |
| sp_sel_o | output | 1 | Selected stack pointer, 1 = user |

## Verification
Maskable requests are tried at levels below, equal to and above the current level, and with the enable flag clear. This separates the strict comparison from a greater-or-equal comparison and from a missing enable check. Fixed sources are driven alone, in pairs and with the enable flag clear, to expose a wrong priority order, a wrong vector address step and any masking of fixed sources. Software numbers 31 and 40 test the boundary of the stack select clearing. Stacked requests test the order between the three kinds, and a write in an acknowledge cycle tests that the acknowledge takes precedence.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  typedef enum logic [1:0] {
    KIND_MASK  = 2'd0,
    KIND_FIXED = 2'd1,
    KIND_SOFT  = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/irq_fixed_sel.sv
module irq_fixed_sel #(
  parameter int NUM_SRC = 9,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_SRC:0]   above;
  logic [NUM_SRC-1:0] grant;

  assign above[NUM_SRC] = 1'b0;

  // highest index wins
  for (genvar g = NUM_SRC - 1; g >= 0; g--) begin : g_pri
    assign above[g] = above[g+1] | req_i[g];
    assign grant[g] = req_i[g] & ~above[g+1];
  end

  assign any_o = above[0];

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (grant[k]) idx_o = IDX_W'(k);
    end
  end

  always_comb begin
    assert_grant_onehot_R7: assert ($onehot0(grant));
  end
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
  parameter int LVL_W = 3
) (
  input  logic             valid_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             ie_i,
  input  logic [LVL_W-1:0] ipl_i,
  output logic             ok_o
);
  assign ok_o = valid_i & ie_i & (level_i > ipl_i);
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  logic             clr_sps_i,
  input  logic             wr_en_i,
  input  logic             wr_ie_i,
  input  logic             wr_sps_i,
  input  logic [LVL_W-1:0] wr_ipl_i,
  output logic             ie_o,
  output logic             sps_o,
  output logic [LVL_W-1:0] ipl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_o  <= 1'b0;
      sps_o <= 1'b0;
      ipl_o <= '0;
    end else if (ack_i) begin
      ie_o <= 1'b0;
      if (clr_sps_i) sps_o <= 1'b0;
    end else if (wr_en_i) begin
      ie_o  <= wr_ie_i;
      sps_o <= wr_sps_i;
      ipl_o <= wr_ipl_i;
    end
  end

  assert_write_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !ack_i) |=> (ie_o == $past(wr_ie_i) && ipl_o == $past(wr_ipl_i)));
  assert_ack_keeps_ipl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> $stable(ipl_o));
endmodule

// File: rtl/irq_accept.sv
module irq_accept
  import irq_accept_pkg::*;
#(
  parameter int              LVL_W     = 3,
  parameter int              NUM_FIXED = 9,
  parameter int              SWI_W     = 6,
  parameter int              SWI_SPLIT = 32,
  parameter int              ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] VEC_BASE = 20'h0FFDC
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mreq_valid_i,
  input  logic [LVL_W-1:0]     mreq_level_i,
  input  logic [SWI_W-1:0]     mreq_vec_i,
  input  logic [NUM_FIXED-1:0] fixed_req_i,
  input  logic                 swi_valid_i,
  input  logic [SWI_W-1:0]     swi_num_i,
  input  logic                 wr_en_i,
  input  logic                 wr_ie_i,
  input  logic                 wr_sps_i,
  input  logic [LVL_W-1:0]     wr_ipl_i,
  output logic                 ack_o,
  output logic [1:0]           ack_kind_o,
  output logic [SWI_W-1:0]     ack_num_o,
  output logic [ADDR_W-1:0]    vec_addr_o,
  output logic                 saved_ie_o,
  output logic                 saved_sps_o,
  output logic [LVL_W-1:0]     saved_ipl_o,
  output logic                 ie_o,
  output logic                 sps_o,
  output logic [LVL_W-1:0]     ipl_o,
  output logic                 sp_sel_o
);
  localparam int IDX_W = $clog2(NUM_FIXED);

  logic             fix_any;
  logic [IDX_W-1:0] fix_idx;
  logic             m_ok;
  logic             swi_take, m_take, clr_sps;
  logic             ie_q, sps_q;
  logic [LVL_W-1:0] ipl_q;
  ack_kind_e        kind;

  irq_fixed_sel #(.NUM_SRC(NUM_FIXED)) u_fixed_sel (
    .req_i (fixed_req_i),
    .any_o (fix_any),
    .idx_o (fix_idx)
  );

  irq_mask_gate #(.LVL_W(LVL_W)) u_mask_gate (
    .valid_i (mreq_valid_i),
    .level_i (mreq_level_i),
    .ie_i    (ie_q),
    .ipl_i   (ipl_q),
    .ok_o    (m_ok)
  );

  assign swi_take = swi_valid_i & ~fix_any;
  assign m_take   = m_ok & ~fix_any & ~swi_valid_i;
  assign ack_o    = fix_any | swi_valid_i | m_ok;
  assign clr_sps  = fix_any | m_take | (swi_take & (swi_num_i < SWI_W'(SWI_SPLIT)));

  always_comb begin
    kind      = KIND_MASK;
    ack_num_o = mreq_vec_i;
    if (fix_any) begin
      kind      = KIND_FIXED;
      ack_num_o = SWI_W'(fix_idx);
    end else if (swi_valid_i) begin
      kind      = KIND_SOFT;
      ack_num_o = swi_num_i;
    end
  end
  assign ack_kind_o = kind;

  assign vec_addr_o = fix_any ? VEC_BASE + ADDR_W'({fix_idx, 2'b00}) : '0;

  irq_flag_reg #(.LVL_W(LVL_W)) u_flag_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_i     (ack_o),
    .clr_sps_i (clr_sps),
    .wr_en_i   (wr_en_i),
    .wr_ie_i   (wr_ie_i),
    .wr_sps_i  (wr_sps_i),
    .wr_ipl_i  (wr_ipl_i),
    .ie_o      (ie_q),
    .sps_o     (sps_q),
    .ipl_o     (ipl_q)
  );

  assign ie_o        = ie_q;
  assign sps_o       = sps_q;
  assign ipl_o       = ipl_q;
  assign saved_ie_o  = ie_q;
  assign saved_sps_o = sps_q;
  assign saved_ipl_o = ipl_q;
  assign sp_sel_o    = sps_q;

  assert_strict_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && ack_kind_o == KIND_MASK) |-> (mreq_level_i > ipl_o && ie_o));
  assert_ie_cleared_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ie_o);
  assert_hw_clears_sps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && ack_kind_o != KIND_SOFT) |=> !sps_o);
  assert_high_swi_keeps_sps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && ack_kind_o == KIND_SOFT && swi_num_i >= SWI_W'(SWI_SPLIT)) |=> $stable(sps_o));
  assert_fixed_unmasked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fixed_req_i) |-> (ack_o && ack_kind_o == KIND_FIXED));
  assert_vec_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && ack_kind_o == KIND_FIXED) |-> (vec_addr_o >= VEC_BASE && vec_addr_o[1:0] == 2'b00));
  assert_swi_over_mask_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swi_valid_i && !(|fixed_req_i)) |-> (ack_kind_o == KIND_SOFT && ack_num_o == swi_num_i));
endmodule

// File: tb/irq_accept_tb_top.sv
module irq_accept_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       mreq_valid;
  logic [2:0] mreq_level;
  logic [5:0] mreq_vec;
  logic [8:0] fixed_req;
  logic       swi_valid;
  logic [5:0] swi_num;
  logic       wr_en, wr_ie, wr_sps;
  logic [2:0] wr_ipl;
  logic       ack;
  logic [1:0] ack_kind;
  logic [5:0] ack_num;
  logic [19:0] vec_addr;
  logic       saved_ie, saved_sps, ie, sps, sp_sel;
  logic [2:0] saved_ipl, ipl;

  irq_accept dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .mreq_valid_i(mreq_valid), .mreq_level_i(mreq_level), .mreq_vec_i(mreq_vec),
    .fixed_req_i(fixed_req), .swi_valid_i(swi_valid), .swi_num_i(swi_num),
    .wr_en_i(wr_en), .wr_ie_i(wr_ie), .wr_sps_i(wr_sps), .wr_ipl_i(wr_ipl),
    .ack_o(ack), .ack_kind_o(ack_kind), .ack_num_o(ack_num), .vec_addr_o(vec_addr),
    .saved_ie_o(saved_ie), .saved_sps_o(saved_sps), .saved_ipl_o(saved_ipl),
    .ie_o(ie), .sps_o(sps), .ipl_o(ipl), .sp_sel_o(sp_sel)
  );

  typedef struct {
    string      tag;
    logic       ack;
    logic [1:0] kind;
    logic [5:0] num;
    logic [19:0] addr;
    logic       ie;
    logic       sps;
    logic [2:0] ipl;
  } exp_t;

  exp_t q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit m_ie = 0, m_sps = 0;
  logic [2:0] m_ipl = 0;

  task automatic cmp(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push expected outputs
  task automatic step(string tag, logic [8:0] fx, logic sv, logic [5:0] sn,
                      logic mv, logic [2:0] ml, logic [5:0] mvec,
                      logic we, logic wie, logic wsps, logic [2:0] wipl);
    exp_t e;
    int hi;
    @(negedge clk);
    fixed_req = fx; swi_valid = sv; swi_num = sn;
    mreq_valid = mv; mreq_level = ml; mreq_vec = mvec;
    wr_en = we; wr_ie = wie; wr_sps = wsps; wr_ipl = wipl;
    e.tag = tag; e.ie = m_ie; e.sps = m_sps; e.ipl = m_ipl;
    e.ack = 0; e.kind = 0; e.num = 0; e.addr = 0;
    hi = -1;
    for (int k = 0; k < 9; k++) if (fx[k]) hi = k;
    if (hi >= 0) begin
      e.ack = 1; e.kind = 1; e.num = 6'(hi); e.addr = 20'h0FFDC + 20'(4 * hi);
    end else if (sv) begin
      e.ack = 1; e.kind = 2; e.num = sn;
    end else if (mv && m_ie && ml > m_ipl) begin
      e.ack = 1; e.kind = 0; e.num = mvec;
    end
    q.push_back(e);
    if (e.ack) begin
      m_ie = 0;
      if (e.kind != 2 || sn < 32) m_sps = 0;
    end else if (we) begin
      m_ie = wie; m_sps = wsps; m_ipl = wipl;
    end
  endtask

  task automatic idle(string tag);
    step(tag, 9'd0, 0, 6'd0, 0, 3'd0, 6'd0, 0, 0, 0, 3'd0);
  endtask

  task automatic wr(string tag, logic wie, logic wsps, logic [2:0] wipl);
    step(tag, 9'd0, 0, 6'd0, 0, 3'd0, 6'd0, 1, wie, wsps, wipl);
  endtask

  // monitor: compare after the stimulus has settled, before the next edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "ack", int'(ack), int'(e.ack));
        if (e.ack) begin
          cmp(e.tag, "kind (R11)", int'(ack_kind), int'(e.kind));
          cmp(e.tag, "num (R11)", int'(ack_num), int'(e.num));
          cmp(e.tag, "saved (R9)", int'({saved_ie, saved_sps, saved_ipl}),
              int'({e.ie, e.sps, e.ipl}));
        end
        cmp(e.tag, "vec_addr (R8)", int'(vec_addr), int'(e.addr));
        cmp(e.tag, "flags", int'({ie, sps, ipl}), int'({e.ie, e.sps, e.ipl}));
        cmp(e.tag, "sp_sel (R6)", int'(sp_sel), int'(e.sps));
      end
    end
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    fixed_req = 0; swi_valid = 0; swi_num = 0; mreq_valid = 0; mreq_level = 0;
    mreq_vec = 0; wr_en = 0; wr_ie = 0; wr_sps = 0; wr_ipl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");
    wr("R10 write", 1, 1, 3'd3);
    step("R3 equal level", 9'd0, 0, 0, 1, 3'd3, 6'd5, 0, 0, 0, 0);
    step("R3 lower level", 9'd0, 0, 0, 1, 3'd2, 6'd5, 0, 0, 0, 0);
    step("R3 higher level", 9'd0, 0, 0, 1, 3'd4, 6'd21, 0, 0, 0, 0);
    idle("R4 R5 after maskable");
    step("R2 disabled", 9'd0, 0, 0, 1, 3'd7, 6'd9, 0, 0, 0, 0);
    step("R7 fixed while disabled", 9'h001, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    wr("R10 write", 1, 1, 3'd7);
    step("R7 reset wins", 9'h108, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R7 pair 4,1", 9'h012, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    wr("R10 write", 1, 1, 3'd0);
    step("R5 swi 40 keeps sps", 9'd0, 1, 6'd40, 0, 0, 0, 0, 0, 0, 0);
    idle("R5 R4 after swi 40");
    wr("R10 write", 1, 1, 3'd1);
    step("R5 swi 31 clears sps", 9'd0, 1, 6'd31, 0, 0, 0, 0, 0, 0, 0);
    idle("R5 after swi 31");
    wr("R10 write", 1, 1, 3'd0);
    step("R11 all three", 9'h020, 1, 6'd50, 1, 3'd6, 6'd3, 0, 0, 0, 0);
    wr("R10 write", 1, 1, 3'd0);
    step("R11 swi over maskable", 9'd0, 1, 6'd50, 1, 3'd6, 6'd3, 0, 0, 0, 0);
    wr("R10 write", 1, 1, 3'd2);
    step("R10 ack beats write", 9'h080, 0, 0, 0, 0, 0, 1, 1, 1, 3'd5);
    wr("R10 write", 1, 1, 3'd7);
    step("R3 level 7 vs 7", 9'd0, 0, 0, 1, 3'd7, 6'd1, 0, 0, 0, 0);
    step("R3 level 6 top ipl", 9'd0, 0, 0, 1, 3'd6, 6'd1, 0, 0, 0, 0);
    idle("R6 final");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule